// File: doc/BRIEF.md
# Power-Fail and Battery-Low Write Guard

This block sits between an asynchronous host bus (active-low chip enable, output enable and write enable, plus address and data) and a byte-wide memory that holds both plain storage and clock registers. It turns the host strobes into clean single-cycle memory reads and write commits in its own clock domain, and it protects the memory while the supply is unreliable.

A digital power-fail input deselects the device: outputs float, no write reaches the memory, and a write already in flight is dropped. When power returns, and after reset, a recovery window of a parameterised number of cycles ignores all accesses. At the end of that window the battery-low input is sampled. If the battery is low, a flag is raised that silently discards the next write attempt and then clears itself, so software can detect the condition by writing a complement and reading it back.

Top module: `pwr_guard`

## Requirements
- R1: While power-fail is high, `host_rdata_oe` is 0, `host_rdata` is 0 and `mem_we` stays 0 whatever the host strobes do.
- R2: With chip enable low, output enable low and write enable high, `host_rdata_oe` is 1 and `host_rdata` carries the memory byte at the host address; with output enable high the outputs float (`host_rdata_oe` 0, `host_rdata` 0).
- R3: A write starts when the later of chip enable and write enable falls and is committed by a one-cycle `mem_we` pulse when the earlier of them rises; the address is the one present at the start and the data the one present just before the end, for both chip-enable-ended and write-enable-ended writes.
- R4: Write enable low disables the outputs even while chip enable and output enable are both low.
- R5: After reset and after every power-fail release, `REC_CYCLES` cycles pass in which no access is accepted; a write whose strobes were already low when the window closes is not started until a fresh falling edge.
- R6: The battery-low input is sampled when the recovery window closes; if it was high, the first write attempt is discarded (memory keeps its old byte) and the following write succeeds.
- R7: A power-fail that arrives during a write aborts it: no address of the memory changes.
- R8: Host strobes, address, data and the status inputs pass a two-flop synchroniser, so a read shows at the outputs two clock edges after the strobes settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset, treated as a power-up |
| pfail | input | 1 | Power out of tolerance (asynchronous) |
| batt_low | input | 1 | Backup battery below its limit (asynchronous) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | AW | Host byte address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data to host, 0 while floated |
| host_rdata_oe | output | 1 | Host data bus drive enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per committed write |
| mem_rdata | input | DW | Memory read data (combinational) |

## Verification
Two functions can land in one cycle: the end of a write, which would commit it, and a guard event that must cancel it, either a power-fail arriving while the strobes are still low or the battery-low flag waiting for its one discarded write. The bench provokes the first by raising power-fail in the middle of a held write and releasing the strobes only while power is still bad, and the second by arming the flag through a power cycle with the battery input high and then writing a known byte. Both are judged at the ports: a later read of the address must return the byte stored before, and a second write after the flag case must land.

// File: rtl/pwr_guard.sv
module pwr_guard #(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int REC_CYCLES = 400000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pfail,
  input  logic          batt_low,
  input  logic          host_ce_n,
  input  logic          host_oe_n,
  input  logic          host_we_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam int SW = 5 + AW + DW;

  logic [SW-1:0] s1, s2;
  logic          pf_s, bl_s, ce_s, oe_s, we_s;
  logic [AW-1:0] a_s, wa;
  logic [DW-1:0] d_s, wd;
  logic [CW-1:0] cnt;
  logic          wr_req, wr_req_q, wr_act, bad, ready, wr_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= {2'b00, 3'b111, {AW{1'b0}}, {DW{1'b0}}};
      s2 <= {2'b00, 3'b111, {AW{1'b0}}, {DW{1'b0}}};
    end else begin
      s1 <= {pfail, batt_low, host_ce_n, host_oe_n, host_we_n, host_addr, host_wdata};
      s2 <= s1;
    end

  assign {pf_s, bl_s, ce_s, oe_s, we_s, a_s, d_s} = s2;

  assign ready  = (cnt == '0) && !pf_s;
  assign wr_req = !ce_s && !we_s;
  assign wr_end = wr_act && !wr_req && !pf_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= CW'(REC_CYCLES);
      bad      <= 1'b0;
      wr_req_q <= 1'b1;
      wr_act   <= 1'b0;
      wa       <= '0;
      wd       <= '0;
    end else begin
      wr_req_q <= wr_req;
      if (pf_s) begin
        cnt    <= CW'(REC_CYCLES);
        wr_act <= 1'b0;
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) bad <= bl_s;
        if (wr_end) begin
          wr_act <= 1'b0;
          bad    <= 1'b0;
        end else if (ready && wr_req && !wr_req_q && !wr_act) begin
          wr_act <= 1'b1;
          wa     <= a_s;
          wd     <= d_s;
        end else if (wr_act) begin
          wd     <= d_s;
        end
      end
    end

  assign mem_we        = wr_end && !bad;
  assign mem_addr      = wr_act ? wa : a_s;
  assign mem_wdata     = wd;
  assign host_rdata_oe = ready && !ce_s && !oe_s && we_s;
  assign host_rdata    = host_rdata_oe ? mem_rdata : '0;

  // R1
  pfail_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> !host_rdata_oe);
  // R7
  pfail_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_s) |=> !wr_act);
  // R5
  recov_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> !wr_act);
  // R3
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R6
  bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bad) && $past(cnt == '0)) |-> $past(wr_act && !wr_req));
endmodule

// File: tb/pwr_guard_tb.sv
module pwr_guard_tb;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int REC = 20;

  logic clk = 0, rst_n = 0, pfail = 0, batt_low = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] host_rdata, mem_wdata, mem_rdata;
  logic host_rdata_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem [2048];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pwr_guard #(.AW(AW), .DW(DW), .REC_CYCLES(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pfail(pfail), .batt_low(batt_low),
    .host_ce_n(ce_n), .host_oe_n(oe_n), .host_we_n(we_n),
    .host_addr(addr), .host_wdata(wdata),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata));

  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  localparam logic [AW+DW-1:0] VEC [8] = '{
    {11'h000, 8'h11}, {11'h7FF, 8'hA5}, {11'h123, 8'h00}, {11'h7F8, 8'hFF},
    {11'h400, 8'h5A}, {11'h001, 8'h80}, {11'h2AA, 8'h3C}, {11'h555, 8'hC3}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_first);
    @(negedge clk); addr = a; wdata = d; ce_n = 0; we_n = 0;
    cyc(4);
    if (ce_first) ce_n = 1; else we_n = 1;
    cyc(4);
    ce_n = 1; we_n = 1;
    cyc(4);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    cyc(4);
    chk(host_rdata_oe === 1'b1, req, host_rdata_oe, 1);
    chk(host_rdata === e, req, host_rdata, e);
    ce_n = 1; oe_n = 1;
    cyc(4);
  endtask

  task automatic power_cycle(input bit bl);
    @(negedge clk); batt_low = bl; pfail = 1;
    cyc(6);
    pfail = 0;
    cyc(REC + 8);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R5 reset state: recovery running, nothing driven
    chk(host_rdata_oe === 1'b0 && mem_we === 1'b0, "R5 reset", host_rdata_oe, 0);
    cyc(REC + 8);

    // R3 / R2 vector table: alternate write-ending strobe
    for (int i = 0; i < 8; i++) wr(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], i[0]);
    for (int i = 0; i < 8; i++) rd(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], "R2 R3 R8 table");

    // R2 output enable high floats
    @(negedge clk); addr = 11'h7FF; ce_n = 0; oe_n = 1;
    cyc(4);
    chk(host_rdata_oe === 1'b0 && host_rdata === '0, "R2 oe high", host_rdata, 0);
    ce_n = 1; cyc(4);

    // R8 latency: one edge after strobes not yet visible, two edges visible
    @(negedge clk); addr = 11'h7FF; ce_n = 0; oe_n = 0;
    @(negedge clk);
    chk(host_rdata_oe === 1'b0, "R8 one edge", host_rdata_oe, 0);
    @(negedge clk);
    chk(host_rdata_oe === 1'b1, "R8 two edges", host_rdata_oe, 1);
    ce_n = 1; oe_n = 1; cyc(4);

    // R4 write enable low disables outputs during ce/oe low
    @(negedge clk); addr = 11'h010; wdata = 8'h77; ce_n = 0; oe_n = 0; we_n = 0;
    cyc(4);
    chk(host_rdata_oe === 1'b0, "R4 we low", host_rdata_oe, 0);
    we_n = 1; cyc(4);
    chk(host_rdata_oe === 1'b1 && host_rdata === 8'h77, "R4 then read", host_rdata, 8'h77);
    ce_n = 1; oe_n = 1; cyc(4);

    // R1 power-fail: read floated, write ignored
    @(negedge clk); pfail = 1; cyc(3);
    addr = 11'h000; ce_n = 0; oe_n = 0; cyc(4);
    chk(host_rdata_oe === 1'b0 && host_rdata === '0, "R1 read floated", host_rdata, 0);
    ce_n = 1; oe_n = 1; cyc(2);
    wr(11'h000, 8'hEE, 0);
    pfail = 0; cyc(REC + 8);
    rd(11'h000, 8'h11, "R1 write ignored");

    // R5 write inside recovery window ignored
    @(negedge clk); pfail = 1; cyc(6); pfail = 0; cyc(2);
    wr(11'h7FF, 8'h01, 1);
    cyc(REC + 8);
    rd(11'h7FF, 8'hA5, "R5 write in window");

    // R5 strobes held low across end of window: no write
    @(negedge clk); pfail = 1; cyc(6);
    addr = 11'h123; wdata = 8'h99; ce_n = 0; we_n = 0;
    pfail = 0; cyc(REC + 10);
    ce_n = 1; we_n = 1; cyc(4);
    rd(11'h123, 8'h00, "R5 held strobes");

    // R7 power-fail in the middle of a write aborts it
    @(negedge clk); addr = 11'h400; wdata = 8'hB2; ce_n = 0; we_n = 0;
    cyc(4);
    pfail = 1; cyc(4);
    ce_n = 1; we_n = 1; cyc(4);
    pfail = 0; cyc(REC + 8);
    rd(11'h400, 8'h5A, "R7 abort");
    rd(11'h555, 8'hC3, "R7 neighbour");

    // R6 battery low: first write dropped, second lands
    power_cycle(1'b1);
    batt_low = 0;
    wr(11'h2AA, 8'hC3, 0);
    rd(11'h2AA, 8'h3C, "R6 first write dropped");
    wr(11'h2AA, 8'hC3, 1);
    rd(11'h2AA, 8'hC3, "R6 second write lands");

    // R6 battery good: first write lands
    power_cycle(1'b0);
    wr(11'h001, 8'h42, 0);
    rd(11'h001, 8'h42, "R6 battery good");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule